// File: doc/BRIEF.md
# Three-Stage Pipeline Sequencing Controller

This block sequences a fetch, decode and execute pipeline. It holds the address the next fetch will read. For each of the three stages it keeps an instruction address and a valid flag, and the decode and execute stages also keep the instruction word. It drives a synchronous instruction memory read port. Read data returns one cycle after the address and is taken as the word of the fetch stage.

The execute stage shows the instruction that completes in the current cycle. It also shows the program-counter value that this instruction reads, which is offset ahead of its own address. The offset is 8 in the 32-bit instruction state and 4 in the 16-bit compact state. When the executing instruction branches or writes the PC, the younger stages are flushed and fetch restarts at the target. A pending fast or normal interrupt is accepted only at an instruction boundary, that is, in a cycle where a valid instruction completes in execute. When one is accepted, the younger stages are flushed, fetch restarts at the interrupt's vector, and a link address is reported for the return.

The instruction state (`compact_i`) is expected to change only while reset is asserted.

Top module: `pipe_seq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `imem_addr_o` is 0x0 and `ex_valid_o` is 0.
- R2: With no redirect, `imem_addr_o` advances by 4 per cycle when `compact_i`=0 and by 2 per cycle when `compact_i`=1. Successive valid executing instructions have addresses that differ by the same step.
- R3: The word the memory returns for an address reaches `ex_instr_o` in the cycle where `ex_pc_o` equals that address and `ex_valid_o` is 1.
- R4: `ex_pcread_o` equals `ex_pc_o`+8 when `compact_i`=0 and `ex_pc_o`+4 when `compact_i`=1.
- R5: A redirect (taken branch or PC write on a valid executing instruction, or an accepted interrupt) has these effects. On the next cycle `imem_addr_o` is the destination. `ex_valid_o` is 0 for three cycles. On the fourth cycle, `ex_valid_o` is 1 and `ex_pc_o` is the destination.
- R6: `ex_redirect_i` has no effect while `ex_valid_o` is 0.
- R7: `exc_take_o` is 1 only in a cycle with `ex_valid_o`=1. Pending interrupts are ignored while `ex_valid_o` is 0.
- R8: `exc_vector_o` is 0x18 for a normal interrupt (`irq_i`) and 0x1C for a fast interrupt (`fiq_i`). The fast interrupt wins when both are pending, and an accepted interrupt overrides a same-cycle branch as the fetch destination.
- R9: `exc_link_o` is one of the following:
  - `ex_target_i` when a branch completes in the same cycle;
  - otherwise the address of the oldest instruction that has not completed (the one in decode), which in steady flow is `ex_pc_o` plus one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compact_i | input | 1 | 1 selects the 16-bit compact instruction state |
| imem_addr_o | output | 32 | Instruction memory read address |
| imem_rdata_i | input | IW | Read data for the address of the previous cycle |
| ex_valid_o | output | 1 | Execute stage holds an instruction completing this cycle |
| ex_pc_o | output | 32 | Address of the executing instruction |
| ex_instr_o | output | IW | Word of the executing instruction |
| ex_pcread_o | output | 32 | PC value the executing instruction reads |
| ex_redirect_i | input | 1 | Executing instruction branches or writes the PC |
| ex_target_i | input | 32 | Branch or PC-write destination |
| irq_i | input | 1 | Normal interrupt pending |
| fiq_i | input | 1 | Fast interrupt pending |
| exc_take_o | output | 1 | Interrupt accepted this cycle |
| exc_vector_o | output | 32 | Vector of the accepted interrupt |
| exc_link_o | output | 32 | Return address for the accepted interrupt |

## Verification
The hardest case to reach is an interrupt arriving in exactly the cycle where a particular instruction completes. This includes the case where that same instruction also branches, which changes both the link and the fetch destination. The stimulus restarts the pipeline from reset for each vector and steps it until the executing address matches the vector's chosen count of instructions. It then raises branch and interrupt inputs in that cycle only. It also raises them while the pipeline is still empty after reset, to show they are ignored there.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;
  localparam int unsigned PC_W = 32;
  localparam logic [PC_W-1:0] VEC_RESET = 32'h0000_0000;
  localparam logic [PC_W-1:0] VEC_IRQ   = 32'h0000_0018;
  localparam logic [PC_W-1:0] VEC_FIQ   = 32'h0000_001C;

  typedef enum logic [1:0] {EXC_NONE, EXC_IRQ, EXC_FIQ} exc_kind_e;

  // size of one instruction in bytes for the current state
  function automatic logic [PC_W-1:0] seq_step(input logic compact);
    return compact ? 32'd2 : 32'd4;
  endfunction

  // PC visible to the executing instruction: two instructions ahead
  function automatic logic [PC_W-1:0] pc_view(input logic [PC_W-1:0] addr,
                                              input logic compact);
    return addr + (seq_step(compact) << 1);
  endfunction

  function automatic logic [PC_W-1:0] vector_of(input exc_kind_e kind);
    case (kind)
      EXC_FIQ: return VEC_FIQ;
      EXC_IRQ: return VEC_IRQ;
      default: return VEC_RESET;
    endcase
  endfunction
endpackage

// File: rtl/pcs_stage.sv
module pcs_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill_i,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else if (kill_i) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/pcs_fetch.sv
module pcs_fetch
  import pipe_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            compact_i,
  input  logic            redir_i,
  input  logic [PC_W-1:0] dest_i,
  output logic [PC_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_o <= VEC_RESET;
    else if (redir_i) addr_o <= dest_i;
    else              addr_o <= addr_o + seq_step(compact_i);
  end
endmodule

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pipe_seq_pkg::*;
(
  input  logic            e_vld_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] br_tgt_i,
  input  logic            irq_i,
  input  logic            fiq_i,
  input  logic            d_vld_i,
  input  logic [PC_W-1:0] d_pc_i,
  input  logic            f_vld_i,
  input  logic [PC_W-1:0] f_pc_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            take_o,
  output logic [PC_W-1:0] vec_o,
  output logic [PC_W-1:0] link_o,
  output logic            redir_o,
  output logic [PC_W-1:0] dest_o
);
  exc_kind_e kind;
  logic      br_eff;

  always_comb begin
    br_eff = e_vld_i && br_i;
    if (!e_vld_i)   kind = EXC_NONE;
    else if (fiq_i) kind = EXC_FIQ;
    else if (irq_i) kind = EXC_IRQ;
    else            kind = EXC_NONE;
    take_o  = (kind != EXC_NONE);
    vec_o   = vector_of(kind);
    redir_o = br_eff || take_o;
    dest_o  = take_o ? vec_o : br_tgt_i;
    if (br_eff)       link_o = br_tgt_i;
    else if (d_vld_i) link_o = d_pc_i;
    else if (f_vld_i) link_o = f_pc_i;
    else              link_o = fetch_pc_i;
  end
endmodule

// File: rtl/pipe_seq_ctrl.sv
module pipe_seq_ctrl
  import pipe_seq_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            compact_i,
  output logic [PC_W-1:0] imem_addr_o,
  input  logic [IW-1:0]   imem_rdata_i,
  output logic            ex_valid_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic [IW-1:0]   ex_instr_o,
  output logic [PC_W-1:0] ex_pcread_o,
  input  logic            ex_redirect_i,
  input  logic [PC_W-1:0] ex_target_i,
  input  logic            irq_i,
  input  logic            fiq_i,
  output logic            exc_take_o,
  output logic [PC_W-1:0] exc_vector_o,
  output logic [PC_W-1:0] exc_link_o
);
  localparam int unsigned SW = PC_W + IW;

  // named internal events, visible to the bound checker
  logic            flush_w;
  logic [PC_W-1:0] dest_w;
  logic            f_vld, d_vld;
  logic [PC_W-1:0] f_pc;
  logic [SW-1:0]   d_dat, e_dat;

  pcs_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .compact_i(compact_i),
    .redir_i(flush_w), .dest_i(dest_w), .addr_o(imem_addr_o)
  );

  pcs_stage #(.W(PC_W)) u_fs (
    .clk(clk), .rst_n(rst_n), .kill_i(flush_w),
    .vld_i(1'b1), .dat_i(imem_addr_o), .vld_o(f_vld), .dat_o(f_pc)
  );

  pcs_stage #(.W(SW)) u_ds (
    .clk(clk), .rst_n(rst_n), .kill_i(flush_w),
    .vld_i(f_vld), .dat_i({f_pc, imem_rdata_i}), .vld_o(d_vld), .dat_o(d_dat)
  );

  pcs_stage #(.W(SW)) u_es (
    .clk(clk), .rst_n(rst_n), .kill_i(flush_w),
    .vld_i(d_vld), .dat_i(d_dat), .vld_o(ex_valid_o), .dat_o(e_dat)
  );

  assign ex_pc_o     = e_dat[SW-1:IW];
  assign ex_instr_o  = e_dat[IW-1:0];
  assign ex_pcread_o = pc_view(ex_pc_o, compact_i);

  pcs_arbiter u_arb (
    .e_vld_i(ex_valid_o), .br_i(ex_redirect_i), .br_tgt_i(ex_target_i),
    .irq_i(irq_i), .fiq_i(fiq_i),
    .d_vld_i(d_vld), .d_pc_i(d_dat[SW-1:IW]),
    .f_vld_i(f_vld), .f_pc_i(f_pc), .fetch_pc_i(imem_addr_o),
    .take_o(exc_take_o), .vec_o(exc_vector_o), .link_o(exc_link_o),
    .redir_o(flush_w), .dest_o(dest_w)
  );
endmodule

// File: rtl/pipe_seq_chk.sv
module pipe_seq_chk
  import pipe_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            compact_i,
  input logic [PC_W-1:0] imem_addr_o,
  input logic            ex_valid_o,
  input logic            fiq_i,
  input logic            exc_take_o,
  input logic [PC_W-1:0] exc_vector_o,
  input logic            flush_w,
  input logic [PC_W-1:0] dest_w,
  input logic            f_vld,
  input logic            d_vld
);
  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (!f_vld && !d_vld && !ex_valid_o));

  // R5
  redirect_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (imem_addr_o == $past(dest_w)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_w |=> (imem_addr_o == $past(imem_addr_o) + ($past(compact_i) ? 32'd2 : 32'd4)));

  // R7
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_o |-> ex_valid_o);

  // R8
  fiq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take_o && fiq_i) |-> (exc_vector_o == 32'h1C));
endmodule

bind pipe_seq_ctrl pipe_seq_chk u_chk (.*);

// File: tb/sim_pipe_seq_ctrl.sv
module sim_pipe_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        c;
    logic [7:0]  n;
    logic        br;
    logic [31:0] tgt;
    logic        irq;
    logic        fiq;
    logic        take;
    logic [31:0] vec;
    logic [31:0] link;
    logic [31:0] dest;
  } vec_t;

  // event raised when the executing address equals n*step
  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd3, 1'b1, 32'h100, 1'b0, 1'b0, 1'b0, 32'h0,  32'h0,   32'h100},
    '{1'b1, 8'd5, 1'b1, 32'h222, 1'b0, 1'b0, 1'b0, 32'h0,  32'h0,   32'h222},
    '{1'b0, 8'd2, 1'b0, 32'h0,   1'b1, 1'b0, 1'b1, 32'h18, 32'hC,   32'h18},
    '{1'b1, 8'd4, 1'b0, 32'h0,   1'b1, 1'b1, 1'b1, 32'h1C, 32'hA,   32'h1C},
    '{1'b0, 8'd1, 1'b1, 32'h400, 1'b1, 1'b0, 1'b1, 32'h18, 32'h400, 32'h18},
    '{1'b1, 8'd0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 32'h1C, 32'h2,   32'h1C}
  };

  logic        clk = 0, rst_n = 0, compact = 0;
  logic [31:0] imem_addr, imem_rdata, ex_pc, ex_instr, ex_pcread;
  logic [31:0] ex_target = 0, exc_vector, exc_link;
  logic        ex_valid, ex_redirect = 0, irq = 0, fiq = 0, exc_take;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  always @(posedge clk) imem_rdata <= word_at(imem_addr);

  pipe_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .compact_i(compact),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .ex_valid_o(ex_valid), .ex_pc_o(ex_pc), .ex_instr_o(ex_instr),
    .ex_pcread_o(ex_pcread), .ex_redirect_i(ex_redirect),
    .ex_target_i(ex_target), .irq_i(irq), .fiq_i(fiq),
    .exc_take_o(exc_take), .exc_vector_o(exc_vector), .exc_link_o(exc_link)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic c);
    @(negedge clk);
    rst_n = 0; compact = c; ex_redirect = 0; irq = 0; fiq = 0;
    @(negedge clk);
    check("R1 addr in reset", imem_addr, 32'h0);
    check("R1 valid in reset", {31'd0, ex_valid}, 32'd0);
    rst_n = 1;
    #1;
    check("R1 addr after reset", imem_addr, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < 6; v++) begin
      logic [31:0] step, want, prev;
      int guard;
      step = VECS[v].c ? 32'd2 : 32'd4;
      want = VECS[v].n * step;
      do_reset(VECS[v].c);
      guard = 0;
      prev  = 32'hFFFF_FFFF;
      @(negedge clk);
      while (!(ex_valid && ex_pc == want) && guard < 50) begin
        if (ex_valid && prev != 32'hFFFF_FFFF)
          check("R2 exec step", ex_pc, prev + step);
        if (ex_valid) prev = ex_pc;
        @(negedge clk);
        guard++;
      end
      check("R2 reached address", ex_pc, want);
      check("R3 instr word", ex_instr, word_at(want));
      check("R4 pc view", ex_pcread, want + 2 * step);
      ex_redirect = VECS[v].br; ex_target = VECS[v].tgt;
      irq = VECS[v].irq; fiq = VECS[v].fiq;
      #1;
      check("R7 take", {31'd0, exc_take}, {31'd0, VECS[v].take});
      if (VECS[v].take) begin
        check("R8 vector", exc_vector, VECS[v].vec);
        check("R9 link", exc_link, VECS[v].link);
      end
      @(negedge clk);
      ex_redirect = 0; irq = 0; fiq = 0;
      check("R5 fetch dest", imem_addr, VECS[v].dest);
      for (int k = 0; k < 3; k++) begin
        check("R5 bubble", {31'd0, ex_valid}, 32'd0);
        @(negedge clk);
      end
      check("R5 valid again", {31'd0, ex_valid}, 32'd1);
      check("R5 exec dest", ex_pc, VECS[v].dest);
      check("R3 dest word", ex_instr, word_at(VECS[v].dest));
    end

    // directed: redirect and interrupts ignored while execute is empty
    do_reset(1'b0);
    ex_redirect = 1; ex_target = 32'h800; irq = 1; fiq = 1;
    #1;
    check("R7 no take when empty", {31'd0, exc_take}, 32'd0);
    @(negedge clk);
    check("R6 branch ignored", imem_addr, 32'h4);
    #1;
    check("R7 no take when empty 2", {31'd0, exc_take}, 32'd0);
    @(negedge clk);
    check("R6 branch ignored 2", imem_addr, 32'h8);
    ex_redirect = 0; irq = 0; fiq = 0;
    @(negedge clk);
    check("R6 first exec valid", {31'd0, ex_valid}, 32'd1);
    check("R6 first exec addr", ex_pc, 32'h0);
    check("R4 pc view 32-bit", ex_pcread, 32'h8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule